// File: doc/BRIEF.md
# Request Tag Allocator

This block issues transaction tags to a requester that sends non-posted requests, and takes each tag back when the matching completion retires. The requester holds `alloc_req` high. The block offers a free tag on a registered `gnt_valid` / `gnt_tag` pair, and the offer stays in place until `gnt_ready` accepts it. A separate release port returns one tag per cycle. A release aimed at a tag that is not outstanding raises a one-cycle error pulse.

The pool size is the smaller of a configured count and a hardware cap. The cap is the wide pool when the extended-tag enable is high and the narrow pool when it is low. The search for a free tag is round-robin. It starts just after the most recently issued tag and wraps at the usable count, so tags are spread evenly across the pool rather than reused at once. When no usable tag is free, the pending request waits. It is served as soon as a release frees a tag.

Top module: `rtag_alloc`

## Requirements
- R1: After reset no grant is offered, no error is raised, no tag is busy, and the last-issued index is 0. The first tag granted after reset is therefore 1, provided the usable count exceeds 1.
- R2: The usable count is min(`tag_limit`, cap). The cap is `WIDE_TAGS` (256) when `ext_tag_en` is 1 and `NARROW_TAGS` (32) when it is 0. Only tags below the usable count are granted.
- R3: The search begins at last-issued + 1. If that value is at or above the usable count, it begins at 0. The search takes the first free tag in ascending order and wraps once, modulo the usable count.
- R4: A granted tag becomes busy. It is not granted again until it has been released.
- R5: When every usable tag is busy, no grant is made. The held request is served in the cycle in which a release frees a tag.
- R6: A release clears the busy bit of `rel_tag`, so that tag becomes grantable again.
- R7: A release and an allocation in the same cycle are ordered release first. The tag being released in that cycle can be granted in that same cycle.
- R8: A release of a tag that is not busy raises `rel_err` for exactly one cycle, in the cycle after the release. `rel_err` is 0 in any cycle not preceded by such a release.
- R9: A grant is made on the clock edge where `alloc_req` is 1, a free tag exists, and the output slot is empty or is being accepted. `gnt_valid` rises on that edge. While `gnt_valid` is 1 and `gnt_ready` is 0, `gnt_valid` and `gnt_tag` hold. At most one grant is made per cycle.
- R10: `tag_limit` is an unsigned count that is one bit wider than a tag. A value of 0 leaves no usable tags, so no grant is ever made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tag_en | input | 1 | Selects the wide tag cap when 1 and the narrow cap when 0 |
| tag_limit | input | TAG_W+1 | Configured upper bound on the usable tag count |
| alloc_req | input | 1 | Requester wants a tag |
| gnt_ready | input | 1 | Requester accepts the offered tag |
| gnt_valid | output | 1 | A tag is offered |
| gnt_tag | output | TAG_W | Offered tag |
| rel_valid | input | 1 | Release strobe |
| rel_tag | input | TAG_W | Tag being released |
| rel_err | output | 1 | One-cycle pulse: the previous release hit a tag that was not busy |

## Verification
The checker assumes that `ext_tag_en` and `tag_limit` are ordinary synchronous inputs. It also assumes that the requester does not depend on `gnt_tag` while `gnt_valid` is low. Its range properties compare a newly raised grant against the usable count of the cycle that produced it. This keeps them valid even when the configuration changes between cycles.

The random stimulus mostly releases tags that are actually busy, and it occasionally sends a stray release so that the error path is exercised. It moves the limit among a small set of values that includes 0, small pools and the full cap. Directed phases fill the narrow pool completely, combine a release with an allocation on the same tag, and hold an offer without acceptance.

// File: rtl/rtag_pkg.sv
package rtag_pkg;

  localparam int DEF_WIDE_TAGS   = 256;
  localparam int DEF_NARROW_TAGS = 32;

  // Smaller of a configured count and a hardware cap.
  function automatic int unsigned clamp_count(int unsigned lim, int unsigned cap);
    return (lim < cap) ? lim : cap;
  endfunction

endpackage

// File: rtl/rtag_count_sel.sv
module rtag_count_sel #(
  parameter int WIDE_TAGS   = rtag_pkg::DEF_WIDE_TAGS,
  parameter int NARROW_TAGS = rtag_pkg::DEF_NARROW_TAGS,
  parameter int CNT_W       = $clog2(WIDE_TAGS) + 1
) (
  input  logic             ext_tag_en,
  input  logic [CNT_W-1:0] tag_limit,
  output logic [CNT_W-1:0] usable
);
  logic [CNT_W-1:0] cap;

  assign cap    = ext_tag_en ? CNT_W'(WIDE_TAGS) : CNT_W'(NARROW_TAGS);
  assign usable = CNT_W'(rtag_pkg::clamp_count(32'(tag_limit), 32'(cap)));
endmodule

// File: rtl/rtag_busy_map.sv
module rtag_busy_map #(
  parameter int N     = 256,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  output logic [N-1:0]     busy_q,
  output logic [N-1:0]     busy_after_rel,
  output logic             rel_err
);
  logic [N-1:0] clr_vec, set_vec, busy_d;

  // Release is applied before any set of the same cycle.
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign clr_vec[i] = rel_valid && (rel_tag == TAG_W'(i));
    assign set_vec[i] = set_en && (set_tag == TAG_W'(i));
  end

  assign busy_after_rel = busy_q & ~clr_vec;
  assign busy_d         = busy_after_rel | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= '0;
      rel_err <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      rel_err <= rel_valid && !busy_q[rel_tag];
    end
  end
endmodule

// File: rtl/rtag_rr_pick.sv
module rtag_rr_pick #(
  parameter int N     = 256,
  parameter int TAG_W = 8,
  parameter int CNT_W = 9
) (
  input  logic [N-1:0]     free_vec,
  input  logic [CNT_W-1:0] usable,
  input  logic [TAG_W-1:0] last,
  output logic             found,
  output logic [TAG_W-1:0] pick
);
  logic [CNT_W-1:0] nxt, start;
  logic [N-1:0]     elig, upper;
  logic [TAG_W-1:0] pick_up, pick_all;

  assign nxt   = CNT_W'(last) + CNT_W'(1);
  assign start = (nxt >= usable) ? '0 : nxt;

  // Split search: the lowest eligible tag at or above start wins; if none,
  // the lowest eligible tag overall (the wrapped part).
  for (genvar i = 0; i < N; i++) begin : g_elig
    assign elig[i]  = free_vec[i] && (CNT_W'(i) < usable);
    assign upper[i] = elig[i] && (CNT_W'(i) >= start);
  end

  always_comb begin
    pick_up  = '0;
    pick_all = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (upper[i]) pick_up  = TAG_W'(i);
      if (elig[i])  pick_all = TAG_W'(i);
    end
  end

  assign found = |elig;
  assign pick  = (|upper) ? pick_up : pick_all;
endmodule

// File: rtl/rtag_alloc.sv
module rtag_alloc #(
  parameter  int WIDE_TAGS   = rtag_pkg::DEF_WIDE_TAGS,
  parameter  int NARROW_TAGS = rtag_pkg::DEF_NARROW_TAGS,
  localparam int TAG_W       = $clog2(WIDE_TAGS),
  localparam int CNT_W       = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_tag_en,
  input  logic [CNT_W-1:0] tag_limit,
  input  logic             alloc_req,
  input  logic             gnt_ready,
  output logic             gnt_valid,
  output logic [TAG_W-1:0] gnt_tag,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             rel_err
);
  logic [CNT_W-1:0]     usable;
  logic [WIDE_TAGS-1:0] busy_q, busy_after_rel;
  logic [TAG_W-1:0]     last_q, pick;
  logic                 found, load;

  rtag_count_sel #(
    .WIDE_TAGS(WIDE_TAGS), .NARROW_TAGS(NARROW_TAGS), .CNT_W(CNT_W)
  ) u_count (
    .ext_tag_en(ext_tag_en), .tag_limit(tag_limit), .usable(usable)
  );

  rtag_busy_map #(.N(WIDE_TAGS), .TAG_W(TAG_W)) u_busy (
    .clk(clk), .rst(rst),
    .rel_valid(rel_valid), .rel_tag(rel_tag),
    .set_en(load), .set_tag(pick),
    .busy_q(busy_q), .busy_after_rel(busy_after_rel), .rel_err(rel_err)
  );

  rtag_rr_pick #(.N(WIDE_TAGS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pick (
    .free_vec(~busy_after_rel), .usable(usable), .last(last_q),
    .found(found), .pick(pick)
  );

  assign load = alloc_req && (!gnt_valid || gnt_ready) && found;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_tag   <= '0;
      last_q    <= '0;
    end else if (load) begin
      gnt_valid <= 1'b1;
      gnt_tag   <= pick;
      last_q    <= pick;
    end else if (gnt_ready) begin
      gnt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtag_alloc_chk.sv
module rtag_alloc_chk #(
  parameter  int WIDE_TAGS   = 256,
  parameter  int NARROW_TAGS = 32,
  localparam int TAG_W       = $clog2(WIDE_TAGS),
  localparam int CNT_W       = TAG_W + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ext_tag_en,
  input logic                 gnt_ready,
  input logic                 gnt_valid,
  input logic [TAG_W-1:0]     gnt_tag,
  input logic                 rel_valid,
  input logic [TAG_W-1:0]     rel_tag,
  input logic                 rel_err,
  input logic [WIDE_TAGS-1:0] busy_q,
  input logic [CNT_W-1:0]     usable
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_tag));

  p_err_r8: assert property (@(posedge clk) disable iff (rst)
    rel_valid && !busy_q[rel_tag] |=> rel_err);

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rel_valid |=> !rel_err);

  p_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_valid) |-> busy_q[gnt_tag]);

  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_valid) |-> (CNT_W'(gnt_tag) < $past(usable)));

  p_narrow_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_valid) && !$past(ext_tag_en) |-> (CNT_W'(gnt_tag) < CNT_W'(NARROW_TAGS)));

  p_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (usable == '0) && !gnt_valid |=> !gnt_valid);
endmodule

bind rtag_alloc rtag_alloc_chk #(.WIDE_TAGS(WIDE_TAGS), .NARROW_TAGS(NARROW_TAGS)) u_chk (
  .clk(clk), .rst(rst), .ext_tag_en(ext_tag_en), .gnt_ready(gnt_ready),
  .gnt_valid(gnt_valid), .gnt_tag(gnt_tag), .rel_valid(rel_valid),
  .rel_tag(rel_tag), .rel_err(rel_err), .busy_q(busy_q), .usable(usable)
);

// File: tb/rtag_alloc_test.sv
`timescale 1ns/1ps
module rtag_alloc_test;
  localparam int WIDE = 256;
  localparam int NARR = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_tag_en = 1'b0;
  logic [8:0] tag_limit = 9'd256;
  logic       alloc_req = 1'b0;
  logic       gnt_ready = 1'b0;
  logic       gnt_valid;
  logic [7:0] gnt_tag;
  logic       rel_valid = 1'b0;
  logic [7:0] rel_tag = '0;
  logic       rel_err;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state, derived from the requirements.
  bit m_busy [WIDE];
  int m_last;
  bit m_gv;
  int m_gt;
  bit m_err;

  always #5 clk = ~clk;

  rtag_alloc uut (
    .clk(clk), .rst(rst), .ext_tag_en(ext_tag_en), .tag_limit(tag_limit),
    .alloc_req(alloc_req), .gnt_ready(gnt_ready), .gnt_valid(gnt_valid),
    .gnt_tag(gnt_tag), .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_err(rel_err)
  );

  function automatic int usable_cnt(bit ext, int lim);
    int cap = ext ? WIDE : NARR;
    return (lim < cap) ? lim : cap;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_busy[i]) m_busy[i] = 1'b0;
    m_last = 0; m_gv = 1'b0; m_gt = 0; m_err = 1'b0;
  endtask

  // Advance the model by one edge using the inputs now being driven.
  task automatic model_step();
    int  n, start, p;
    bit  fnd, nerr;
    nerr = rel_valid && !m_busy[rel_tag];
    if (rel_valid) m_busy[rel_tag] = 1'b0;           // release first (R7)
    n = usable_cnt(ext_tag_en, int'(tag_limit));
    start = (m_last + 1 >= n) ? 0 : m_last + 1;
    fnd = 1'b0; p = 0;
    for (int k = 0; k < n; k++) begin
      int idx = (start + k) % n;
      if (!fnd && !m_busy[idx]) begin fnd = 1'b1; p = idx; end
    end
    if (alloc_req && (!m_gv || gnt_ready) && fnd) begin
      m_busy[p] = 1'b1; m_last = p; m_gv = 1'b1; m_gt = p;
    end else if (gnt_ready) begin
      m_gv = 1'b0;
    end
    m_err = nerr;
  endtask

  // One clock: inputs are set before the call; outputs are compared at the next negedge.
  task automatic tick(string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(req, "gnt_valid", int'(gnt_valid), int'(m_gv));
    if (m_gv) check(req, "gnt_tag", int'(gnt_tag), m_gt);
    check(req, "rel_err", int'(rel_err), int'(m_err));
  endtask

  task automatic do_reset();
    rst = 1'b1; alloc_req = 1'b0; gnt_ready = 1'b0; rel_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #(200000 * 10);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    @(negedge clk);
    do_reset();
    check("R1", "reset gnt_valid", int'(gnt_valid), 0);
    check("R1", "reset rel_err", int'(rel_err), 0);

    // Narrow pool: first tag is 1, then ascending with wrap to 0 (R1, R3, R2).
    ext_tag_en = 1'b0; tag_limit = 9'd256; alloc_req = 1'b1; gnt_ready = 1'b1;
    tick("R1");
    check("R1", "first tag", int'(gnt_tag), 1);
    for (int k = 0; k < 31; k++) tick("R3");
    check("R3", "wrap tag", int'(gnt_tag), 0);
    // All 32 busy: no grant (R5).
    tick("R5");
    check("R5", "stall", int'(gnt_valid), 0);
    tick("R5");

    // Release and allocate the same tag together (R7).
    rel_valid = 1'b1; rel_tag = 8'd5;
    tick("R7");
    check("R7", "same-cycle tag", int'(gnt_tag), 5);
    rel_valid = 1'b0; alloc_req = 1'b0;
    tick("R7");

    // Stray release raises a single error pulse (R8).
    rel_valid = 1'b1; rel_tag = 8'd40;
    tick("R8");
    check("R8", "err pulse", int'(rel_err), 1);
    rel_valid = 1'b0;
    tick("R8");
    check("R8", "err cleared", int'(rel_err), 0);

    // Free tag 10, then hold the offer without acceptance (R6, R9).
    rel_valid = 1'b1; rel_tag = 8'd10;
    tick("R6");
    rel_valid = 1'b0; alloc_req = 1'b1; gnt_ready = 1'b0;
    for (int k = 0; k < 3; k++) tick("R9");
    check("R6", "freed tag reissued", int'(gnt_tag), 10);
    check("R9", "offer held", int'(gnt_valid), 1);
    gnt_ready = 1'b1; alloc_req = 1'b0;
    tick("R9");

    // Zero limit grants nothing (R10).
    do_reset();
    tag_limit = 9'd0; ext_tag_en = 1'b1; alloc_req = 1'b1; gnt_ready = 1'b1;
    for (int k = 0; k < 3; k++) tick("R10");
    check("R10", "no grant at limit 0", int'(gnt_valid), 0);

    // Limit 4 with wide cap: 1,2,3,0 then stall (R2).
    tag_limit = 9'd4;
    for (int k = 0; k < 4; k++) tick("R2");
    check("R2", "limit wrap", int'(gnt_tag), 0);
    tick("R2");
    check("R2", "limit stall", int'(gnt_valid), 0);

    // Wide pool reaches past the narrow cap (R2).
    do_reset();
    ext_tag_en = 1'b1; tag_limit = 9'd256; alloc_req = 1'b1; gnt_ready = 1'b1;
    for (int k = 0; k < 40; k++) tick("R2");
    check("R2", "wide tag", int'(gnt_tag), 40);

    // Random traffic (R4, R5, R6, R8, R9).
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 200) == 0) begin
        int sel = $urandom % 5;
        tag_limit = (sel == 0) ? 9'd0 : (sel == 1) ? 9'd4 : (sel == 2) ? 9'd32 :
                    (sel == 3) ? 9'd100 : 9'd256;
        ext_tag_en = (($urandom % 4) != 0);
      end
      alloc_req = (($urandom % 4) != 0);
      gnt_ready = (($urandom % 3) != 0);
      rel_valid = (($urandom % 2) == 0);
      rel_tag   = 8'($urandom);
      if (($urandom % 16) != 0) begin
        int s = $urandom % WIDE;
        for (int k = 0; k < WIDE; k++) begin
          if (m_busy[(s + k) % WIDE]) begin rel_tag = 8'((s + k) % WIDE); break; end
        end
      end
      tick("R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule